// File: doc/BRIEF.md
# Self-Recovering Serial Command Decoder

This block listens to a single serial command line, sampled once per system clock, and turns the bit stream into actions. A short fast pattern fires a one-cycle trigger strobe toward the front-end chips after a fixed latency. Longer slow commands, which open with a fixed header, carry a type and a register address. They can write a 16-bit value into a small local register file, read a register back as a serial bit stream, broadcast a global-reset strobe to the surrounding logic, or simply realign the decoder.

The decoder has no reset command of its own. The global-reset command clears the register file and pulses an output for the neighbouring blocks, but it leaves the decoder's state alone. Recovery from a garbled stream is done by a free-running watchdog counter. Whenever that counter passes through zero, the decoder is forced back to idle from any other state. A pattern that matches nothing parks the decoder in a discard state until that moment. The active-low pin reset clears every flop at once.

Top module: `selfheal_cmd_decoder`

## Requirements
- R1: While rst_n is low and after its release, trig_o, sdo_o and grst_o are 0, and every register reads back 0.
- R2: If the four bits 1,1,0,1 appear on cmd_i in cycles n to n+3 while the decoder is idle, trig_o is high in cycle n+8.
- R3: A trigger strobe lasts exactly one cycle.
- R4: A write is the header 1,0,1,1,0, then the type 0001, then a 4-bit address, then 16 data bits, all MSB first. The data is stored in the addressed register.
- R5: A read is the header, the type 0010 and a 4-bit address. The register is shifted out on sdo_o MSB first over the 16 cycles that start in the cycle after the last address bit. sdo_o is 0 at all other times.
- R6: A sync command (header, type 0000, any address) has no visible effect, and a new command may start in the cycle right after its last bit.
- R7: A global-reset command (header, type 0011) drives grst_o high for one cycle, the cycle after its last bit, and clears every register to 0. The decoder itself is not reset.
- R8: A pattern that matches neither the trigger nor the header, or a header followed by any other type code, puts the decoder in a discard state. In that state it ignores all commands.
- R9: A free-running 16-bit counter starts at 0 at reset release and increments every cycle. In the cycle where it reads 0, any non-idle decoder state returns to idle, so a discarded decoder accepts commands again from cycle 65537.
- R10: Bits arriving while a command is still being executed, such as during a read, are ignored.
- R11: While the command line stays at 0, no output toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, all sampling on rising edge |
| rst_n | input | 1 | Active-low pin reset, clears every flop |
| cmd_i | input | 1 | Serial command line, idles at 0 |
| trig_o | output | 1 | One-cycle trigger strobe to the front ends |
| sdo_o | output | 1 | Serial read-back data, MSB first |
| grst_o | output | 1 | One-cycle global-reset strobe to neighbouring blocks |

## Verification
A wrong decoder state shows first as a trigger strobe that arrives in the wrong cycle, or not at all. It can also show as read-back bits that are shifted by one position or carry a stale register value. All of these appear within 17 cycles of the command that exposed them. A decoder that fails to leave its discard state is only visible after the counter wraps: a trigger sent just after cycle 65536 must still produce its strobe. For this reason the scoreboard follows both counter wraps, at 65536 and 131072 cycles.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_FIELD,
    ST_WDATA,
    ST_READ,
    ST_TWAIT,
    ST_DISCARD
  } dec_state_t;

  localparam logic [3:0] TRIG_PAT = 4'b1101;
  localparam logic [4:0] HDR_PAT  = 5'b10110;

  localparam logic [3:0] TY_SYNC = 4'h0;
  localparam logic [3:0] TY_WR   = 4'h1;
  localparam logic [3:0] TY_RD   = 4'h2;
  localparam logic [3:0] TY_GRST = 4'h3;

  function automatic logic is_trig(input logic [3:0] bits);
    return bits == TRIG_PAT;
  endfunction

  function automatic logic is_hdr(input logic [4:0] bits);
    return bits == HDR_PAT;
  endfunction

endpackage

// File: rtl/cmdd_watchdog.sv
module cmdd_watchdog #(
  parameter int WD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic wd_zero
);
  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign wd_zero = (cnt_q == '0);

  // R9: zero is only passed through, never held
  p_wd_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_zero |=> !wd_zero);
endmodule

// File: rtl/cmdd_regfile.sv
module cmdd_regfile #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R7: after a clear strobe every location reads zero
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rdata == '0));
endmodule

// File: rtl/cmdd_fsm.sv
module cmdd_fsm
  import cmdd_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int TRIG_LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_i,
  input  logic          wd_zero,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          trig_o,
  output logic          sdo_o,
  output logic          grst_o
);
  localparam int CW = $clog2(DW) + 1;
  localparam logic [CW-1:0] TWAIT_LD  = CW'(TRIG_LAT - 5);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_FLD  = CW'(AW + 3);

  dec_state_t    st;
  logic [DW-1:0] sh, ro;
  logic [DW-1:0] nxt_sh;
  logic [CW-1:0] bc;
  logic [3:0]    typ;

  assign nxt_sh = {sh[DW-2:0], cmd_i};
  assign typ    = nxt_sh[AW+3:AW];
  assign raddr  = nxt_sh[AW-1:0];
  assign sdo_o  = (st == ST_READ) & ro[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; ro <= '0; bc <= '0;
      trig_o <= 1'b0; grst_o <= 1'b0; we <= 1'b0;
      waddr <= '0; wdata <= '0;
    end else begin
      trig_o <= 1'b0;
      grst_o <= 1'b0;
      we     <= 1'b0;
      if (wd_zero && st != ST_IDLE) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (cmd_i) begin
            sh <= {{(DW-1){1'b0}}, 1'b1};
            bc <= CW'(1);
            st <= ST_HDR;
          end
          ST_HDR: begin
            sh <= nxt_sh;
            bc <= bc + 1'b1;
            if (bc == CW'(3) && is_trig(nxt_sh[3:0])) begin
              st <= ST_TWAIT;
              bc <= TWAIT_LD;
            end else if (bc == CW'(4)) begin
              bc <= '0;
              st <= is_hdr(nxt_sh[4:0]) ? ST_FIELD : ST_DISCARD;
            end
          end
          ST_FIELD: begin
            sh <= nxt_sh;
            bc <= bc + 1'b1;
            if (bc == LAST_FLD) begin
              bc    <= '0;
              waddr <= nxt_sh[AW-1:0];
              case (typ)
                TY_SYNC: st <= ST_IDLE;
                TY_GRST: begin grst_o <= 1'b1; st <= ST_IDLE; end
                TY_WR:   st <= ST_WDATA;
                TY_RD:   begin ro <= rdata; st <= ST_READ; end
                default: st <= ST_DISCARD;
              endcase
            end
          end
          ST_WDATA: begin
            sh <= nxt_sh;
            bc <= bc + 1'b1;
            if (bc == LAST_DATA) begin
              we    <= 1'b1;
              wdata <= nxt_sh;
              st    <= ST_IDLE;
            end
          end
          ST_READ: begin
            ro <= {ro[DW-2:0], 1'b0};
            bc <= bc + 1'b1;
            if (bc == LAST_DATA) st <= ST_IDLE;
          end
          ST_TWAIT: begin
            if (bc == '0) begin
              trig_o <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              bc <= bc - 1'b1;
            end
          end
          default: ; // ST_DISCARD waits for the watchdog
        endcase
      end
    end
  end

  // R3: strobe is a single cycle
  p_trig_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  // R2: strobe only ends a latency wait
  p_trig_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(st) == ST_TWAIT));
  // R9: watchdog zero forces idle
  p_wd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_zero && st != ST_IDLE) |=> (st == ST_IDLE));
  // R8: discard holds until the watchdog
  p_discard_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DISCARD && !wd_zero) |=> (st == ST_DISCARD));
  // R7: global-reset strobe is a single cycle
  p_grst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grst_o |=> !grst_o);
endmodule

// File: rtl/selfheal_cmd_decoder.sv
module selfheal_cmd_decoder #(
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int WD_W     = 16,
  parameter int TRIG_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  output logic trig_o,
  output logic sdo_o,
  output logic grst_o
);
  logic          wd_zero;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;

  cmdd_watchdog #(.WD_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .wd_zero(wd_zero)
  );

  cmdd_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(grst_o), .we(we),
    .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  cmdd_fsm #(.DW(DW), .AW(AW), .TRIG_LAT(TRIG_LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .wd_zero(wd_zero),
    .rdata(rdata), .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
    .trig_o(trig_o), .sdo_o(sdo_o), .grst_o(grst_o)
  );
endmodule

// File: tb/selfheal_cmd_decoder_tb.sv
module selfheal_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WRAP = 65536;

  typedef struct {
    int    cyc;
    int    kind;   // 0 trig, 1 sdo, 2 grst
    logic  val;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, cmd = 1'b0;
  logic trig, sdo, grst;
  int cyc = 0, checks = 0, fails = 0;
  bit running = 0, done = 0;
  string ctx = "R11";
  exp_t q[$];
  logic [15:0] model [16];

  selfheal_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
    .trig_o(trig), .sdo_o(sdo), .grst_o(grst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(string req, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, expv);
    end
  endtask

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) if (running && !done) begin
    logic [2:0] ev;
    string rq [3];
    ev = 3'b000;
    rq[0] = ctx; rq[1] = ctx; rq[2] = ctx;
    while (q.size() > 0 && q[0].cyc < cyc) begin
      fails++; checks++;
      $display("FAIL %s stale item cycle %0d: actual none expected %0d", q[0].req, cyc, q[0].cyc);
      void'(q.pop_front());
    end
    while (q.size() > 0 && q[0].cyc == cyc) begin
      ev[q[0].kind] = q[0].val;
      rq[q[0].kind] = q[0].req;
      void'(q.pop_front());
    end
    chk(rq[0], "trig_o", trig, ev[0]);
    chk(rq[1], "sdo_o", sdo, ev[1]);
    chk(rq[2], "grst_o", grst, ev[2]);
  end

  task automatic put(int n, logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      cmd = v[i];
      @(negedge clk);
    end
    cmd = 1'b0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_trig(bit fires, string req);
    if (fires) q.push_back('{cyc + 8, 0, 1'b1, req});
    put(4, 32'b1101);
  endtask

  task automatic do_write(logic [3:0] a, logic [15:0] d, bit takes);
    put(13, {19'd0, 5'b10110, 4'b0001, a});
    put(16, {16'd0, d});
    if (takes) model[a] = d;
    gap(4);
  endtask

  task automatic do_read(logic [3:0] a, string req, int tail);
    int ca;
    ca = cyc + 12;
    for (int k = 0; k < 16; k++) q.push_back('{ca + 1 + k, 1, model[a][15-k], req});
    put(13, {19'd0, 5'b10110, 4'b0010, a});
    gap(tail);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    // R1: outputs low during pin reset
    repeat (3) @(negedge clk);
    chk("R1", "trig_o in reset", trig, 1'b0);
    chk("R1", "sdo_o in reset", sdo, 1'b0);
    chk("R1", "grst_o in reset", grst, 1'b0);
    rst_n = 1'b1;
    running = 1;
    gap(5);
    // R1: register reads zero after reset
    do_read(4'h5, "R1", 20);
    // R2 trigger latency, R3 single cycle via quiet checks
    ctx = "R3";
    do_trig(1, "R2"); gap(12);
    do_trig(1, "R2"); gap(9);
    // R4 writes then R5 reads
    ctx = "R4";
    do_write(4'h3, 16'hA5C3, 1);
    do_write(4'hF, 16'hFFFF, 1);
    do_write(4'h0, 16'h0001, 1);
    ctx = "R5";
    do_read(4'h3, "R5", 20);
    do_read(4'hF, "R5", 20);
    do_read(4'h0, "R4", 20);
    // R6: sync, then trigger on the very next cycle
    ctx = "R6";
    put(13, {19'd0, 5'b10110, 4'b0000, 4'h3});
    do_trig(1, "R6"); gap(12);
    do_read(4'h3, "R6", 20);
    // R10: trigger pattern during a read is ignored
    ctx = "R10";
    do_read(4'h3, "R5", 0);
    put(4, 32'b1101);
    gap(30);
    // R7: global reset clears registers, decoder still accepts commands
    ctx = "R7";
    q.push_back('{cyc + 13, 2, 1'b1, "R7"});
    put(13, {19'd0, 5'b10110, 4'b0011, 4'h9});
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    gap(4);
    do_read(4'h3, "R7", 20);
    do_read(4'hF, "R7", 20);
    // R8: lone 1 discards; following commands ignored
    do_write(4'h7, 16'h1234, 1);
    ctx = "R8";
    put(5, 32'b10000);
    gap(3);
    do_trig(0, "R8"); gap(12);
    do_write(4'h7, 16'h0000, 0);
    // R9: recovery after the first counter wrap
    while (cyc < WRAP + 4) @(negedge clk);
    ctx = "R9";
    do_trig(1, "R9"); gap(12);
    do_read(4'h7, "R8", 20);
    // R8: unknown type code discards too
    ctx = "R8";
    put(13, {19'd0, 5'b10110, 4'b1111, 4'h2});
    do_trig(0, "R8"); gap(12);
    while (cyc < 2 * WRAP + 4) @(negedge clk);
    ctx = "R9";
    do_trig(1, "R9"); gap(12);
    // R11: idle line stays quiet
    ctx = "R11";
    gap(50);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 leftover items: actual %0d expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule